// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that gives a stalled system one chance to recover before it asks for a reset. A counter is loaded from a programmable period register and counts down on each tick input. When the count runs out for the first time, the block does not request a reset. It sets an expiry flag in its status register and starts a fresh countdown. If the count runs out again while that flag is still set, the block raises a one-cycle system reset request and returns all of its own state to the reset values.

Software, or a management handler, keeps the system alive in one of two ways. It can pulse the reload strobe, which restarts the countdown and clears the flag in one step. It can also clear the flag by writing a one to the flag bit of the status register. The time from the last service to the reset request therefore lies between a little more than one period and about two periods. A control bit can suppress the reset request. In that mode the flag still latches, which makes the block useful as a plain timeout detector.

Register map, all byte-wide: address 0 holds the period, address 1 holds the control register, address 2 holds the status register, and address 3 is unused.

Top module: `wdt_two_stage`

## Requirements
- R1: After the asynchronous reset, the registers read as follows: period = RST_PERIOD, control = 0x00, status = 0x00. sys_rst_o is low, and the counter holds RST_PERIOD.
- R2: Each tick_i decrements the counter by one. The tick that arrives while the counter is 1 or 0 is an expiry, and at that expiry the counter reloads from the period register. So a loaded value P gives an expiry on tick number max(P,1).
- R3: An expiry while the flag is clear sets the flag, which is status bit 3. It does not raise sys_rst_o.
- R4: An expiry while the flag is set, with no-reboot off, raises sys_rst_o for exactly one cycle, starting at the clock edge that samples the expiring tick.
- R5: At that same edge every register returns to its R1 value: period = RST_PERIOD, control = 0, flag = 0, counter = RST_PERIOD.
- R6: A write to the status register clears the flag only when data bit 3 is 1. All other data bits are ignored. A read of the status register returns the flag in bit 3 and zeros in all other bits.
- R7: reload_i loads the counter from the period register and clears the flag. It takes priority over a tick in the same cycle, and that tick is not counted.
- R8: Control bit 0 is the no-reboot option. When it is set, a second expiry raises no sys_rst_o, the flag stays set, and counting goes on. Control reads back bit 0 only, with bits 7..1 read as 0.
- R9: When an expiry and a status clear fall in the same cycle, the expiry wins. If the flag was clear, it ends up set. If the flag was set, the reset of R4 is requested.
- R10: A write to the period register does not change a countdown that is already running. The new value is used from the next reload or expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 period, 1 control, 2 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| reload_i | input | 1 | Keepalive: reloads the counter and clears the flag |
| tick_i | input | 1 | Timebase tick, one count per asserted cycle |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check several properties on every cycle:
- the counter steps down by exactly one per tick and holds when idle;
- a first expiry always latches the flag;
- a keepalive always leaves the flag clear;
- a reset pulse lasts one cycle and only follows an expiry with the flag set;
- no pulse comes out while no-reboot was set;
- the status read shows nothing outside bit 3.

Some behaviours span many cycles or depend on order, and only the bench scenarios show them:
- the exact tick on which each expiry lands;
- the rule that a period write waits for the next reload;
- the precedence of an expiry over a same-cycle flag clear;
- the full return to reset values after a pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = 2;
  localparam int FLAG_BIT     = 3;
  localparam int NOREBOOT_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD = 2'd0,
    REG_CTRL   = 2'd1,
    REG_STATUS = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int              CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_clr_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // reload masks the tick: no expiry in a keepalive cycle
  assign expire_o = tick_i && !reload_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= RST_VAL;
    else if (soft_clr_i) cnt_q <= RST_VAL;
    else if (reload_i)   cnt_q <= period_i;
    else if (expire_o)   cnt_q <= period_i;
    else if (tick_i)     cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_TICK_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !reload_i && !soft_clr_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reload_i && !soft_clr_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic keepalive_i,
  input  logic w1c_i,
  input  logic no_reboot_i,
  output logic flag_o,
  output logic fire_o,
  output logic rst_req_o
);
  logic flag_q, rst_q;

  assign fire_o    = expire_i && flag_q && !no_reboot_i;
  assign flag_o    = flag_q;
  assign rst_req_o = rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= fire_o;
      if (fire_o)                    flag_q <= 1'b0;
      else if (expire_i)             flag_q <= 1'b1; // set beats a same-cycle clear
      else if (keepalive_i || w1c_i) flag_q <= 1'b0;
    end
  end

  AST_FIRST_EXPIRY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !flag_q) |=> flag_q); // R3
  AST_RST_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q); // R4
  AST_RST_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> ($past(flag_q) && $past(expire_i))); // R4
  AST_RST_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> !flag_q); // R5
  AST_KEEPALIVE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keepalive_i |=> !flag_q); // R7
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_PERIOD = 8'd255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] period_o,
  output logic              no_reboot_o,
  output logic              flag_clr_o
);
  logic [DATA_W-1:0] period_q;
  logic              no_reboot_q;
  reg_addr_e         sel;

  assign sel         = reg_addr_e'(addr_i);
  assign period_o    = period_q;
  assign no_reboot_o = no_reboot_q;
  assign flag_clr_o  = we_i && (sel == REG_STATUS) && wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q    <= RST_PERIOD;
      no_reboot_q <= 1'b0;
    end else if (soft_clr_i) begin
      period_q    <= RST_PERIOD;
      no_reboot_q <= 1'b0;
    end else if (we_i) begin
      if (sel == REG_PERIOD) period_q    <= wdata_i;
      if (sel == REG_CTRL)   no_reboot_q <= wdata_i[NOREBOOT_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_PERIOD: rdata_o = period_q;
      REG_CTRL:   rdata_o[NOREBOOT_BIT] = no_reboot_q;
      REG_STATUS: rdata_o[FLAG_BIT] = flag_i;
      default:    rdata_o = '0;
    endcase
  end

  AST_STATUS_READ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == REG_STATUS) |-> ((rdata_o & ~(DATA_W'(1) << FLAG_BIT)) == '0)); // R6
  AST_SOFT_CLR_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (period_q == RST_PERIOD && !no_reboot_q)); // R5
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_PERIOD = 8'd255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              reload_i,
  input  logic              tick_i,
  output logic              sys_rst_o
);
  logic [DATA_W-1:0] period;
  logic no_reboot, flag, flag_clr, expire, fire;

  wdt_regs #(.RST_PERIOD(RST_PERIOD)) u_regs (
    .clk_i, .rst_ni,
    .soft_clr_i (fire),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .flag_i     (flag),
    .rdata_o    (reg_rdata_o),
    .period_o   (period),
    .no_reboot_o(no_reboot),
    .flag_clr_o (flag_clr)
  );

  wdt_counter #(.CNT_W(DATA_W), .RST_VAL(RST_PERIOD)) u_cnt (
    .clk_i, .rst_ni,
    .soft_clr_i(fire),
    .tick_i    (tick_i),
    .reload_i  (reload_i),
    .period_i  (period),
    .expire_o  (expire)
  );

  wdt_stage u_stage (
    .clk_i, .rst_ni,
    .expire_i   (expire),
    .keepalive_i(reload_i),
    .w1c_i      (flag_clr),
    .no_reboot_i(no_reboot),
    .flag_o     (flag),
    .fire_o     (fire),
    .rst_req_o  (sys_rst_o)
  );

  AST_NO_REBOOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !$past(no_reboot)); // R8
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  localparam logic [7:0] RP = 8'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, tick = 1'b0, reload = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sys_rst;
  int n_tests = 0, n_fail = 0, pulses = 0;

  always #5 clk = ~clk;

  wdt_two_stage #(.RST_PERIOD(RP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reload_i(reload),
    .tick_i(tick), .sys_rst_o(sys_rst)
  );

  always @(negedge clk) if (rst_n && sys_rst) pulses++;

  // {we, addr, wdata, expected readback}
  localparam logic [18:0] VEC [7] = '{
    {1'b0, 2'd0, 8'h00, 8'h05},  // R1 period default
    {1'b1, 2'd0, 8'h03, 8'h03},  // R10 period write (count untouched)
    {1'b1, 2'd1, 8'hFE, 8'h00},  // R8 only bit 0 stored
    {1'b1, 2'd1, 8'h01, 8'h01},  // R8
    {1'b1, 2'd1, 8'h00, 8'h00},  // R8
    {1'b1, 2'd2, 8'hFF, 8'h00},  // R6 clear of clear flag
    {1'b0, 2'd3, 8'h00, 8'h00}   // R6 unused address
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     input logic tk, input logic rl);
    we = w; addr = a; wdata = d; tick = tk; reload = rl;
    @(negedge clk);
    we = 1'b0; tick = 1'b0; reload = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 period", v, RP);
    rd(2'd1, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    chk("R1 sys_rst", sys_rst, 0);

    foreach (VEC[i]) begin
      if (VEC[i][18]) cyc(1'b1, VEC[i][17:16], VEC[i][15:8], 1'b0, 1'b0);
      rd(VEC[i][17:16], v);
      chk($sformatf("R6/R8/R10 vec %0d", i), v, VEC[i][7:0]);
    end

    // R2/R10: running count is still 5 although period is now 3
    ticks(4); rd(2'd2, v); chk("R10 no early expiry", v, 8'h00);
    ticks(1); rd(2'd2, v); chk("R3 first expiry flag", v, 8'h08);
    chk("R3 no reset", pulses, 0);
    ticks(2); rd(2'd2, v); chk("R2 reload from period", v, 8'h08);
    chk("R3 still no reset", pulses, 0);
    cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0); rd(2'd2, v); chk("R6 zero write ignored", v, 8'h08);
    cyc(1'b1, 2'd2, 8'hF7, 1'b0, 1'b0); rd(2'd2, v); chk("R6 other bits ignored", v, 8'h08);
    cyc(1'b1, 2'd2, 8'h08, 1'b0, 1'b0); rd(2'd2, v); chk("R6 w1c clears", v, 8'h00);
    ticks(1); rd(2'd2, v); chk("R3 expiry sets again", v, 8'h08);
    chk("R3 no pulse", pulses, 0);
    ticks(2); chk("R4 not yet", sys_rst, 0);
    ticks(1); chk("R4 pulse high", sys_rst, 1);
    @(negedge clk); chk("R4 pulse one cycle", sys_rst, 0);
    chk("R4 pulse count", pulses, 1);
    rd(2'd0, v); chk("R5 period restored", v, RP);
    rd(2'd2, v); chk("R5 flag cleared", v, 0);

    // R7: reload with tick, counter restarted at 5
    ticks(4);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1);
    ticks(4); rd(2'd2, v); chk("R7 reload beats tick", v, 8'h00);
    ticks(1); rd(2'd2, v); chk("R2 expiry on 5th tick", v, 8'h08);
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1); rd(2'd2, v); chk("R7 reload clears flag", v, 8'h00);

    // R8: no-reboot
    cyc(1'b1, 2'd1, 8'h01, 1'b0, 1'b0);
    cyc(1'b1, 2'd0, 8'h02, 1'b0, 1'b0);
    p0 = pulses;
    ticks(5); rd(2'd2, v); chk("R8 first expiry", v, 8'h08);
    ticks(4); rd(2'd2, v); chk("R8 flag stays", v, 8'h08);
    rd(2'd1, v); chk("R8 ctrl kept", v, 8'h01);
    chk("R8 no pulse", pulses, p0);

    // R9: expiry vs clear in the same cycle
    cyc(1'b1, 2'd1, 8'h00, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
    ticks(1);
    cyc(1'b1, 2'd2, 8'h08, 1'b1, 1'b0);
    rd(2'd2, v); chk("R9 set wins", v, 8'h08);
    chk("R9 no pulse", pulses, p0);
    ticks(1);
    cyc(1'b1, 2'd2, 8'h08, 1'b1, 1'b0);
    chk("R9 reset despite clear", sys_rst, 1);
    @(negedge clk); chk("R9 pulse count", pulses, p0 + 1);

    // R2 period 0: every tick expires
    cyc(1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
    ticks(1); rd(2'd2, v); chk("R2 zero period expiry", v, 8'h08);
    ticks(1); chk("R4 zero period reset", sys_rst, 1);
    @(negedge clk);
    rd(2'd0, v); chk("R5 period after reset", v, RP);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule